// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is a synchronous master that reads one conversion at a time from a 12-bit successive-approximation converter over a three-wire serial link: an active-low select, a serial clock and a serial data input. A frame starts on a one-cycle `start` pulse or on a tick from an internal rate timer. The converter samples its input on the falling edge of select and uses the serial clock to run the conversion, so the frame length is fixed.

When a frame starts, the controller drives select low. It then produces exactly 16 serial clock periods from the system clock, with each half period lasting `DIV_HALF` system cycles, and shifts in one data bit on every falling edge of the serial clock. A frame holds four zero bits followed by a 12-bit result, most significant bit first. After the last bit the controller raises select, presents the result with a one-cycle strobe, and flags the frame when any of the four leading bits was not zero. It then keeps select high for a quiet gap before the next frame may begin. A start request that arrives while a frame or a gap is in progress is held and is served as soon as the gap ends.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held, and after it is released with no request, `cs_n` and `sclk` are high and `valid` is low.
- R2: A `start` pulse sampled while the block is idle drives `cs_n` low at the next rising clock edge.
- R3: A frame keeps `cs_n` low for exactly 32×`DIV_HALF` system cycles and produces exactly 16 falling edges of `sclk`. `sclk` is high when `cs_n` falls.
- R4: Within a frame, each `sclk` level lasts exactly `DIV_HALF` cycles, including the first high level after `cs_n` falls and the last low level before `cs_n` rises. `sclk` is high whenever `cs_n` is high.
- R5: `sdata` is sampled on each `sclk` falling edge. The 16 samples form a word with the first sample at bit 15, and `result` equals bits 11..0 of that word.
- R6: `valid` is high for exactly one cycle, the first cycle in which `cs_n` is high again after a frame, and never at any other time. `frame_error` in that cycle is 1 when bits 15..12 of the word are not all zero, and 0 otherwise.
- R7: Between two frames `cs_n` stays high for at least `QUIET_CYC`+1 cycles.
- R8: Start requests that arrive during a frame or a quiet gap merge into one pending request. That request launches exactly one frame, and its `cs_n` falls exactly `QUIET_CYC`+1 cycles after the previous rise.
- R9: With `rate_en` high and `rate_period` non-zero, the timer launches frames whose `cs_n` falling edges are exactly `rate_period` cycles apart, as long as `rate_period` exceeds the frame and gap length.
- R10: With `rate_en` low and no `start`, no frame is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle conversion request |
| rate_en | input | 1 | Enables the periodic trigger timer |
| rate_period | input | RATE_W | Timer period in system cycles |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low select; its falling edge starts the conversion |
| sclk | output | 1 | Serial clock, idles high |
| result | output | 12 | Last conversion result |
| valid | output | 1 | One-cycle strobe for a new result |
| frame_error | output | 1 | Leading bits of the last frame were not zero |

## Verification
Each result has a fixed due cycle. `cs_n` falls one edge after an accepted `start`, or one edge after a timer tick. Every `sclk` transition follows the previous one or the select fall by `DIV_HALF` cycles. `valid`, `result` and `frame_error` appear in the same cycle that `cs_n` rises, 32×`DIV_HALF` cycles after it fell. The next fall comes no earlier than `QUIET_CYC`+1 cycles later. The bench counts system cycles, samples every port on the falling system edge, and compares each event with these offsets. This means a result that is one cycle late or early is reported at the cycle where it was due.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV_HALF  = 13,
  parameter int QUIET_CYC = 16,
  parameter int RATE_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rate_en,
  input  logic [RATE_W-1:0] rate_period,
  input  logic              sdata,
  output logic              cs_n,
  output logic              sclk,
  output logic [11:0]       result,
  output logic              valid,
  output logic              frame_error
);
  localparam int CMAX = (DIV_HALF > QUIET_CYC) ? DIV_HALF : QUIET_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {IDLE, LEAD, LOW, HIGH, QUIET} state_t;

  state_t            st;
  logic [CW-1:0]     cnt;
  logic [4:0]        nfall;
  logic [15:0]       shreg;
  logic              pend;
  logic [RATE_W-1:0] rcnt;

  wire tick      = rate_en && (rate_period != '0) && (rcnt == rate_period - 1'b1);
  wire req       = start || pend || tick;
  wire launch    = (st == IDLE) && req;
  wire half_done = (cnt == CW'(DIV_HALF - 1));
  wire quiet_end = (cnt == CW'(QUIET_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0;
      pend <= 1'b0;
    end else begin
      rcnt <= (!rate_en || tick) ? '0 : rcnt + 1'b1;
      pend <= (pend || start || tick) && !launch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      cnt         <= '0;
      nfall       <= '0;
      shreg       <= '0;
      cs_n        <= 1'b1;
      sclk        <= 1'b1;
      result      <= '0;
      valid       <= 1'b0;
      frame_error <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        IDLE: begin
          if (launch) begin
            cs_n  <= 1'b0;
            cnt   <= '0;
            nfall <= '0;
            st    <= LEAD;
          end
        end
        LEAD, HIGH: begin
          if (half_done) begin
            sclk  <= 1'b0;
            shreg <= {shreg[14:0], sdata};
            nfall <= nfall + 1'b1;
            cnt   <= '0;
            st    <= LOW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        LOW: begin
          if (half_done) begin
            sclk <= 1'b1;
            cnt  <= '0;
            if (nfall == 5'd16) begin
              cs_n        <= 1'b1;
              valid       <= 1'b1;
              result      <= shreg[11:0];
              frame_error <= |shreg[15:12];
              st          <= QUIET;
            end else begin
              st <= HIGH;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        QUIET: begin
          if (quiet_end) begin
            cnt <= '0;
            st  <= IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module adc_frame_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic valid
);
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  assert_sclk_high_at_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sclk);
  assert_valid_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $rose(cs_n));
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
endmodule

bind adc_frame_reader adc_frame_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .valid(valid)
);

// File: tb/sim_adc_frame_reader.sv
`timescale 1ns/1ps
module sim_adc_frame_reader;
  localparam int H  = 13;
  localparam int Q  = 16;
  localparam int RW = 16;
  localparam int RATE_P = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rate_en = 1'b0;
  logic [RW-1:0] rate_period = RW'(RATE_P);
  logic sdata = 1'b0;
  logic cs_n, sclk, valid, frame_error;
  logic [11:0] result;

  always #2 clk = ~clk;

  adc_frame_reader #(.DIV_HALF(H), .QUIET_CYC(Q), .RATE_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_en(rate_en),
    .rate_period(rate_period), .sdata(sdata), .cs_n(cs_n), .sclk(sclk),
    .result(result), .valid(valid), .frame_error(frame_error)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] make_word(input int i);
    logic [15:0] v;
    case (i)
      0: v = 16'h0FFF;
      1: v = 16'h0000;
      2: v = 16'h0800;
      3: v = 16'h8001;
      4: v = 16'h1555;
      default: begin
        v[11:0]  = 12'($urandom);
        v[15:12] = ($urandom % 4 == 0) ? 4'($urandom % 15 + 1) : 4'h0;
      end
    endcase
    return v;
  endfunction

  logic [15:0] words [64];
  logic [15:0] w;
  int adc_n = 0;
  int bidx = 0;

  always @(negedge cs_n) begin
    w = words[adc_n % 64];
    adc_n++;
    bidx = 15;
    sdata = w[15];
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      #1;
      if (bidx > 0) begin
        bidx--;
        sdata = w[bidx];
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc++;

  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  int t_fall = 0, t_edge = 0, t_rise = 0, nf = 0, frames = 0, last_gap = 0, mon_n = 0;
  bit have_rise = 1'b0, rate_mode = 1'b0, prev_fall_rate = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        if (have_rise) begin
          last_gap = cyc - t_rise;
          chk(last_gap >= Q + 1, "R7 quiet gap", last_gap, Q + 1);
        end
        if (rate_mode && prev_fall_rate)
          chk(cyc - t_fall == RATE_P, "R9 timer spacing", cyc - t_fall, RATE_P);
        prev_fall_rate = rate_mode;
        t_fall = cyc;
        t_edge = cyc;
        nf = 0;
      end else if (!cs_n && sclk != prev_sclk) begin
        chk(cyc - t_edge == H, "R4 sclk phase", cyc - t_edge, H);
        t_edge = cyc;
        if (!sclk) nf++;
      end
      if (!prev_cs && cs_n) begin
        logic [15:0] e;
        e = words[mon_n % 64];
        mon_n++;
        frames++;
        t_rise = cyc;
        have_rise = 1'b1;
        chk(cyc - t_fall == 32 * H, "R3 select low length", cyc - t_fall, 32 * H);
        chk(nf == 16, "R3 falling edge count", nf, 16);
        chk(cyc - t_edge == H, "R4 last low phase", cyc - t_edge, H);
        chk(valid == 1'b1, "R6 valid at select rise", int'(valid), 1);
        chk(result == e[11:0], "R5 result", int'(result), int'(e[11:0]));
        chk(frame_error == (|e[15:12]), "R6 frame_error", int'(frame_error), int'(|e[15:12]));
      end else if (valid) begin
        chk(1'b0, "R6 stray valid", 1, 0);
      end
      if (cs_n && !sclk) chk(1'b0, "R4 sclk low while idle", 0, 1);
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (cs_n) @(negedge clk);
    while (!cs_n) @(negedge clk);
  endtask

  task automatic one_frame();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cs_n == 1'b0, "R2 select falls after start", int'(cs_n), 0);
    while (!cs_n) @(negedge clk);
    wait_cyc(Q + 2);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) words[i] = make_word(i);

    wait_cyc(5);
    chk(cs_n == 1'b1, "R1 reset select", int'(cs_n), 1);
    chk(sclk == 1'b1, "R1 reset sclk", int'(sclk), 1);
    chk(valid == 1'b0, "R1 reset valid", int'(valid), 0);
    rst_n = 1'b1;
    wait_cyc(5);
    chk(cs_n == 1'b1 && sclk == 1'b1 && valid == 1'b0, "R1 idle after reset",
        int'({cs_n, sclk, valid}), 6);

    for (int i = 0; i < 5; i++) one_frame();
    for (int i = 0; i < 25; i++) begin
      wait_cyc(int'($urandom % 20));
      one_frame();
    end

    begin
      int f0;
      f0 = frames;
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_cyc(50);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_cyc(100);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_cyc(2000);
      chk(frames - f0 == 2, "R8 merged pending frame count", frames - f0, 2);
      chk(last_gap == Q + 1, "R8 pending gap", last_gap, Q + 1);
    end

    begin
      int f0;
      f0 = frames;
      start = 1'b1; @(negedge clk); start = 1'b0;
      while (!cs_n) @(negedge clk);
      wait_cyc(3);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_cyc(1000);
      chk(frames - f0 == 2, "R8 start in quiet gap", frames - f0, 2);
      chk(last_gap == Q + 1, "R8 quiet gap pending launch", last_gap, Q + 1);
    end

    begin
      int f0;
      f0 = frames;
      wait_cyc(2000);
      chk(frames == f0, "R10 no frame without trigger", frames - f0, 0);
    end

    begin
      int f0;
      f0 = frames;
      rate_mode = 1'b1;
      rate_en = 1'b1;
      for (int i = 0; i < 6; i++) wait_rise();
      rate_en = 1'b0;
      rate_mode = 1'b0;
      wait_cyc(RATE_P + 50);
      chk(frames - f0 == 6, "R9 timer frame count", frames - f0, 6);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule